// File: doc/BRIEF.md
# LAPS Frame Receive Validator

This block sits behind an HDLC-style deframer on the receive side of a link that carries Ethernet frames inside LAPS framing. The deframer has already found the flags and removed the bit or octet stuffing. It hands over one frame at a time as a byte stream, with a start marker on the first byte, an end marker on the last byte, and an abort marker that may accompany the end marker. The validator checks the four-octet header against four programmable expected values. It runs a CRC-32 frame check over the whole frame and watches for the illegal escape-then-flag octet pair. It also rejects frames that are too short.

The header octets and the four FCS octets are removed, so only the encapsulated MAC frame bytes leave the block, together with their own start and end markers. A bad frame is flagged on its last forwarded byte. A one-cycle status strobe per frame gives the overall verdict and one bit per reject cause. A separate interrupt pulse reports a mismatch of the high SAPI octet when it is enabled. Two saturating counters tally accepted and rejected frames.

Top module: `laps_rx_validator`

## Requirements
- R1: Input byte positions count from 0 at the byte that carries in_sof. Positions 0 to 3 are the header and the last four bytes are the FCS. Only the bytes between them are forwarded, in order, with out_sof on the first and out_eof on the last. A forwarded byte appears on the output one cycle after the input byte that lies four positions after it. A frame of eight or fewer bytes forwards nothing.
- R2: The frame check runs over every byte of the frame, the FCS included. It uses the LSB-first CRC-32 (reflected polynomial 0xEDB88320), with the register preset to all ones. If the final register differs from 0xDEBB20E3, cause bit 1 is set.
- R3: Cause bit 0 is set when a byte 0x7D is followed by a byte 0x7E as consecutive valid bytes of the same frame.
- R4: Cause bit 2 is set when the frame holds fewer than MIN_OCTETS bytes (6 by default).
- R5: Cause bit 3 is set when position 0 differs from cfg_addr, position 1 differs from cfg_ctrl, or position 3 differs from cfg_sapi_lo. Cause bit 4 is set when position 2 differs from cfg_sapi_hi. Positions that the frame does not reach are not compared.
- R6: Cause bit 5 is set when in_abort is high on the frame's last byte.
- R7: frm_done pulses for one cycle, one cycle after each last byte. frm_cause holds that frame's cause bits, and frm_bad is their OR. out_bad is high on the last forwarded byte exactly when the frame is bad.
- R8: sapi_irq pulses together with frm_done when cause bit 4 is set and sapi_irq_en is high. Otherwise it stays low.
- R9: good_cnt counts frames with frm_bad low and abort_cnt counts frames with frm_bad high. Each steps once per frame, in the same cycle as frm_done, and holds at all ones.
- R10: While rst_n is low, every output is zero.
- R11: A byte with in_valid low, or a valid byte that arrives outside a frame without in_sof, produces no output and no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_abort | input | 1 | Deframer abort, read with in_eof |
| cfg_addr | input | 8 | Expected address octet |
| cfg_ctrl | input | 8 | Expected control octet |
| cfg_sapi_hi | input | 8 | Expected first SAPI octet |
| cfg_sapi_lo | input | 8 | Expected second SAPI octet |
| sapi_irq_en | input | 1 | Enable for the SAPI-high interrupt |
| out_valid | output | 1 | Forwarded byte present |
| out_data | output | 8 | Forwarded MAC frame byte |
| out_sof | output | 1 | First forwarded byte |
| out_eof | output | 1 | Last forwarded byte |
| out_bad | output | 1 | Frame rejected, on the last forwarded byte |
| frm_done | output | 1 | Per-frame status strobe |
| frm_bad | output | 1 | Frame rejected |
| frm_cause | output | 6 | Reject causes: 0 escape, 1 FCS, 2 short, 3 header, 4 SAPI high, 5 upstream abort |
| sapi_irq | output | 1 | SAPI-high mismatch interrupt pulse |
| good_cnt | output | CNT_W | Accepted frame counter |
| abort_cnt | output | CNT_W | Rejected frame counter |

## Verification
The bench builds the block with CNT_W set to 3, so both frame counters reach their all-ones ceiling within about a hundred frames. The saturation hold of R9 is therefore exercised many times instead of needing millions of frames. MIN_OCTETS and IDX_W keep their defaults. The directed short frames of one to nine bytes then cover both sides of the six-octet limit, as well as the frames that forward no payload. Frames with random gaps, random header, FCS and escape faults, and a mid-run change of the expected header values are mixed with these directed cases.

// File: rtl/laps_rx_pkg.sv
package laps_rx_pkg;
   localparam int HDR_LEN = 4;
   localparam int FCS_LEN = 4;
   localparam int CAUSE_W = 6;
   localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;
   localparam logic [31:0] CRC_GOOD   = 32'hDEBB20E3;

   // Bit order matches the frm_cause port: esc is bit 0, upab is bit 5.
   typedef struct packed {
      logic upab;
      logic sapih;
      logic hdr;
      logic shrt;
      logic fcs;
      logic esc;
   } cause_t;

   function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c ^ {24'h0, d};
      for (int b = 0; b < 8; b++) begin
         r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
      end
      return r;
   endfunction
endpackage

// File: rtl/laps_fcs_strip.sv
module laps_fcs_strip #(
   parameter int DEPTH = 4,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         push,
   input  logic [W-1:0] din,
   output logic         pop,
   output logic [W-1:0] pop_data
);
   localparam int FW = $clog2(DEPTH + 1);

   logic [W-1:0]  stage [DEPTH];
   logic [FW-1:0] fill_q;
   logic [FW-1:0] fill_c;

   assign fill_c   = clear ? '0 : fill_q;
   assign pop      = push && (fill_c == FW'(DEPTH));
   assign pop_data = stage[DEPTH-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             fill_q <= '0;
      else if (clear || push) fill_q <= fill_c + FW'(push && !pop);
   end

   for (genvar k = 0; k < DEPTH; k++) begin : g_stage
      if (k == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    stage[k] <= '0;
            else if (push) stage[k] <= din;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    stage[k] <= '0;
            else if (push) stage[k] <= stage[k-1];
         end
      end
   end
endmodule

// File: rtl/laps_frame_check.sv
module laps_frame_check
   import laps_rx_pkg::*;
#(
   parameter int IDX_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             take,
   input  logic [IDX_W-1:0] idx,
   input  logic [7:0]       data,
   input  logic [7:0]       cfg_addr,
   input  logic [7:0]       cfg_ctrl,
   input  logic [7:0]       cfg_sapi_hi,
   input  logic [7:0]       cfg_sapi_lo,
   output logic             esc_o,
   output logic             fcs_bad_o,
   output logic             hdr_o,
   output logic             sapih_o
);
   logic [31:0] crc_q, crc_c, crc_n;
   logic        esc_q, prev7d_q, hdr_q, sapih_q;
   logic        esc_c, prev7d_c, hdr_c, sapih_c;

   // Verdicts include the byte presented this cycle.
   always_comb begin
      crc_c    = start ? '1   : crc_q;
      esc_c    = start ? 1'b0 : esc_q;
      prev7d_c = start ? 1'b0 : prev7d_q;
      hdr_c    = start ? 1'b0 : hdr_q;
      sapih_c  = start ? 1'b0 : sapih_q;
      crc_n     = crc32_byte(crc_c, data);
      fcs_bad_o = (crc_n != CRC_GOOD);
      esc_o     = esc_c | (prev7d_c && data == 8'h7E);
      hdr_o     = hdr_c | (idx == IDX_W'(0) && data != cfg_addr)
                        | (idx == IDX_W'(1) && data != cfg_ctrl)
                        | (idx == IDX_W'(3) && data != cfg_sapi_lo);
      sapih_o   = sapih_c | (idx == IDX_W'(2) && data != cfg_sapi_hi);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q    <= '1;
         esc_q    <= 1'b0;
         prev7d_q <= 1'b0;
         hdr_q    <= 1'b0;
         sapih_q  <= 1'b0;
      end else if (take) begin
         crc_q    <= crc_n;
         esc_q    <= esc_o;
         prev7d_q <= (data == 8'h7D);
         hdr_q    <= hdr_o;
         sapih_q  <= sapih_o;
      end
   end
endmodule

// File: rtl/laps_sat_counter.sv
module laps_sat_counter #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   count <= '0;
      else if (inc && count != TOP) count <= count + 1'b1;
   end
endmodule

// File: rtl/laps_rx_validator.sv
module laps_rx_validator
   import laps_rx_pkg::*;
#(
   parameter int CNT_W      = 24,
   parameter int IDX_W      = 12,
   parameter int MIN_OCTETS = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [7:0]         in_data,
   input  logic               in_sof,
   input  logic               in_eof,
   input  logic               in_abort,
   input  logic [7:0]         cfg_addr,
   input  logic [7:0]         cfg_ctrl,
   input  logic [7:0]         cfg_sapi_hi,
   input  logic [7:0]         cfg_sapi_lo,
   input  logic               sapi_irq_en,
   output logic               out_valid,
   output logic [7:0]         out_data,
   output logic               out_sof,
   output logic               out_eof,
   output logic               out_bad,
   output logic               frm_done,
   output logic               frm_bad,
   output logic [CAUSE_W-1:0] frm_cause,
   output logic               sapi_irq,
   output logic [CNT_W-1:0]   good_cnt,
   output logic [CNT_W-1:0]   abort_cnt
);
   localparam logic [IDX_W-1:0] IDX_MAX = '1;
   localparam logic [IDX_W:0]   MIN_L   = (IDX_W+1)'(MIN_OCTETS);

   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("CNT_W must be at least 2");
   end
   if (IDX_W < 4 || MIN_OCTETS < 1 || MIN_OCTETS >= (1 << IDX_W)) begin : g_bad_min
      $error("MIN_OCTETS must fit the byte index width");
   end

   logic             start, take, last, push, pop, in_frame_q, first_q, first_c;
   logic [IDX_W-1:0] idx_q, idx_c;
   logic [7:0]       pop_data;
   logic             esc_n, fcs_bad_n, hdr_n, sapih_n;
   cause_t           cause_n;
   logic             bad_n;

   assign start = in_valid && in_sof;
   assign take  = in_valid && (in_sof || in_frame_q);
   assign last  = take && in_eof;
   assign idx_c = start ? '0 : idx_q;
   assign push  = take && (idx_c >= IDX_W'(HDR_LEN));
   assign first_c = start ? 1'b1 : first_q;

   laps_frame_check #(.IDX_W(IDX_W)) u_check (
      .clk(clk), .rst_n(rst_n), .start(start), .take(take), .idx(idx_c),
      .data(in_data), .cfg_addr(cfg_addr), .cfg_ctrl(cfg_ctrl),
      .cfg_sapi_hi(cfg_sapi_hi), .cfg_sapi_lo(cfg_sapi_lo),
      .esc_o(esc_n), .fcs_bad_o(fcs_bad_n), .hdr_o(hdr_n), .sapih_o(sapih_n)
   );

   laps_fcs_strip #(.DEPTH(FCS_LEN), .W(8)) u_strip (
      .clk(clk), .rst_n(rst_n), .clear(start), .push(push), .din(in_data),
      .pop(pop), .pop_data(pop_data)
   );

   always_comb begin
      cause_n.esc   = esc_n;
      cause_n.fcs   = fcs_bad_n;
      cause_n.shrt  = (({1'b0, idx_c}) + 1'b1) < MIN_L;
      cause_n.hdr   = hdr_n;
      cause_n.sapih = sapih_n;
      cause_n.upab  = in_abort;
      bad_n         = |cause_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         idx_q      <= '0;
         first_q    <= 1'b0;
      end else if (take) begin
         in_frame_q <= !in_eof;
         idx_q      <= (idx_c == IDX_MAX) ? idx_c : idx_c + 1'b1;
         first_q    <= first_c && !pop;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_sof   <= 1'b0;
         out_eof   <= 1'b0;
         out_bad   <= 1'b0;
         frm_done  <= 1'b0;
         frm_bad   <= 1'b0;
         frm_cause <= '0;
         sapi_irq  <= 1'b0;
      end else begin
         out_valid <= pop;
         out_data  <= pop ? pop_data : out_data;
         out_sof   <= pop && first_c;
         out_eof   <= pop && last;
         out_bad   <= pop && last && bad_n;
         frm_done  <= last;
         frm_bad   <= last && bad_n;
         frm_cause <= last ? cause_n : '0;
         sapi_irq  <= last && sapih_n && sapi_irq_en;
      end
   end

   laps_sat_counter #(.W(CNT_W)) u_good_cnt (
      .clk(clk), .rst_n(rst_n), .inc(last && !bad_n), .count(good_cnt)
   );
   laps_sat_counter #(.W(CNT_W)) u_abort_cnt (
      .clk(clk), .rst_n(rst_n), .inc(last && bad_n), .count(abort_cnt)
   );
endmodule

// File: rtl/laps_rx_validator_chk.sv
module laps_rx_validator_chk #(
   parameter int CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             out_valid,
   input logic             out_sof,
   input logic             out_eof,
   input logic             out_bad,
   input logic             frm_done,
   input logic             frm_bad,
   input logic [5:0]       frm_cause,
   input logic             sapi_irq,
   input logic [CNT_W-1:0] good_cnt,
   input logic [CNT_W-1:0] abort_cnt
);
   p_markers_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sof || out_eof) |-> out_valid);

   p_bad_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_bad |-> (out_eof && frm_done && frm_bad));

   p_cause_in_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_cause != 6'd0) |-> (frm_done && frm_bad));

   p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sapi_irq |-> (frm_done && frm_cause[4]));

   p_abort_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (abort_cnt == $past(abort_cnt) ||
                abort_cnt == CNT_W'($past(abort_cnt) + 1'b1)));

   p_abort_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_cnt == {CNT_W{1'b1}}) |=> (abort_cnt == {CNT_W{1'b1}}));

   p_good_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (good_cnt == {CNT_W{1'b1}}) |=> (good_cnt == {CNT_W{1'b1}}));

   p_good_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_done |=> $stable(good_cnt) || frm_done);
endmodule

bind laps_rx_validator laps_rx_validator_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_sof(out_sof),
   .out_eof(out_eof), .out_bad(out_bad), .frm_done(frm_done), .frm_bad(frm_bad),
   .frm_cause(frm_cause), .sapi_irq(sapi_irq), .good_cnt(good_cnt),
   .abort_cnt(abort_cnt)
);

// File: tb/laps_rx_validator_tb_top.sv
module laps_rx_validator_tb_top;
   localparam int CNT_W = 3;
   localparam int CMAX  = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_abort = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic [7:0] cfg_addr = 8'h04, cfg_ctrl = 8'h03, cfg_sapi_hi = 8'hFE, cfg_sapi_lo = 8'h01;
   logic sapi_irq_en = 1'b0;
   logic out_valid, out_sof, out_eof, out_bad, frm_done, frm_bad, sapi_irq;
   logic [7:0] out_data;
   logic [5:0] frm_cause;
   logic [CNT_W-1:0] good_cnt, abort_cnt;

   always #10 clk = ~clk;

   laps_rx_validator #(.CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_sof(in_sof), .in_eof(in_eof), .in_abort(in_abort),
      .cfg_addr(cfg_addr), .cfg_ctrl(cfg_ctrl), .cfg_sapi_hi(cfg_sapi_hi),
      .cfg_sapi_lo(cfg_sapi_lo), .sapi_irq_en(sapi_irq_en),
      .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
      .out_eof(out_eof), .out_bad(out_bad), .frm_done(frm_done),
      .frm_bad(frm_bad), .frm_cause(frm_cause), .sapi_irq(sapi_irq),
      .good_cnt(good_cnt), .abort_cnt(abort_cnt)
   );

   int n_chk = 0, n_err = 0;
   logic [7:0] fb [0:255];
   int flen = 0;
   bit fab = 0;
   logic [7:0] ep [0:255];
   int eplen = 0;
   logic [5:0] ecause = '0;
   bit eirq = 0;
   int egood = 0, eabort = 0;
   logic [7:0] rb [0:255];
   int rlen = 0, sof_err = 0, n_done = 0, n_sent = 0, quiet_viol = 0;
   bit rbad_seen = 0, quiet = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] bench_crc(input int n);
      logic [31:0] c = '1;
      for (int i = 0; i < n; i++) begin
         c ^= {24'h0, fb[i]};
         for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
      return c;
   endfunction

   task automatic build(input int plen, input int hdr_bad, input bit fcs_ok, input int esc_at);
      logic [31:0] c;
      fb[0] = cfg_addr; fb[1] = cfg_ctrl; fb[2] = cfg_sapi_hi; fb[3] = cfg_sapi_lo;
      for (int i = 0; i < plen; i++) fb[4+i] = 8'($urandom);
      if (esc_at >= 0) begin fb[4+esc_at] = 8'h7D; fb[5+esc_at] = 8'h7E; end
      if (hdr_bad >= 0) fb[hdr_bad] ^= 8'(1 << ($urandom % 8));
      c = ~bench_crc(4 + plen);
      for (int k = 0; k < 4; k++) fb[4+plen+k] = c[8*k +: 8];
      flen = plen + 8;
      if (!fcs_ok) fb[flen-1] ^= 8'h80;
   endtask

   task automatic compute_expect();
      ecause = '0;
      for (int i = 1; i < flen; i++) if (fb[i-1] == 8'h7D && fb[i] == 8'h7E) ecause[0] = 1;
      ecause[1] = (bench_crc(flen) != 32'hDEBB20E3);
      ecause[2] = (flen < 6);
      ecause[3] = (flen > 0 && fb[0] != cfg_addr) || (flen > 1 && fb[1] != cfg_ctrl) ||
                  (flen > 3 && fb[3] != cfg_sapi_lo);
      ecause[4] = (flen > 2 && fb[2] != cfg_sapi_hi);
      ecause[5] = fab;
      eirq = sapi_irq_en && ecause[4];
      eplen = (flen > 8) ? flen - 8 : 0;
      for (int i = 0; i < eplen; i++) ep[i] = fb[4+i];
   endtask

   task automatic send(input int gap_pct);
      compute_expect();
      for (int i = 0; i < flen; i++) begin
         while (($urandom % 100) < gap_pct) begin
            @(negedge clk); in_valid = 0; in_data = 8'($urandom); in_sof = 0; in_eof = 0;
         end
         @(negedge clk);
         in_valid = 1; in_data = fb[i]; in_sof = (i == 0); in_eof = (i == flen - 1);
         in_abort = (i == flen - 1) && fab;
      end
      @(negedge clk); in_valid = 0; in_sof = 0; in_eof = 0; in_abort = 0;
      repeat (3) @(negedge clk);
      n_sent++;
      chk(n_done == n_sent, "R7", "one status strobe per frame", n_done, n_sent);
   endtask

   // Sample 2 ns after the rising edge, well away from the driver at the falling edge.
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         if (quiet && (out_valid || frm_done)) quiet_viol++;
         if (out_valid) begin
            if (out_sof != (rlen == 0)) sof_err++;
            if (rlen < 256) rb[rlen] = out_data;
            rlen++;
            if (out_eof) rbad_seen = out_bad;
         end
         if (frm_done) begin
            int mism = 0;
            n_done++;
            if (ecause != 0) begin if (eabort < CMAX) eabort++; end
            else if (egood < CMAX) egood++;
            for (int i = 0; i < eplen && i < rlen; i++) if (rb[i] != ep[i]) mism++;
            chk(rlen == eplen, "R1", "forwarded length", rlen, eplen);
            chk(mism == 0, "R1", "forwarded byte mismatches", mism, 0);
            chk(sof_err == 0, "R1", "start marker errors", sof_err, 0);
            chk(frm_cause[1] == ecause[1], "R2", "fcs cause", frm_cause[1], ecause[1]);
            chk(frm_cause[0] == ecause[0], "R3", "escape cause", frm_cause[0], ecause[0]);
            chk(frm_cause[2] == ecause[2], "R4", "short cause", frm_cause[2], ecause[2]);
            chk(frm_cause[3] == ecause[3], "R5", "header cause", frm_cause[3], ecause[3]);
            chk(frm_cause[4] == ecause[4], "R5", "sapi high cause", frm_cause[4], ecause[4]);
            chk(frm_cause[5] == ecause[5], "R6", "upstream abort cause", frm_cause[5], ecause[5]);
            chk(frm_bad == (ecause != 0), "R7", "frame verdict", frm_bad, ecause != 0);
            chk(rbad_seen == (eplen > 0 && ecause != 0), "R7", "bad marker on last byte",
                rbad_seen, eplen > 0 && ecause != 0);
            chk(sapi_irq == eirq, "R8", "sapi interrupt", sapi_irq, eirq);
            chk(good_cnt == CNT_W'(egood), "R9", "good counter", good_cnt, egood);
            chk(abort_cnt == CNT_W'(eabort), "R9", "abort counter", abort_cnt, eabort);
            rlen = 0; sof_err = 0; rbad_seen = 0;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL R7 watchdog expired: actual=%0d expected=%0d frames", n_done, n_sent);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      #3 rst_n = 0;
      repeat (3) @(negedge clk);
      chk(!out_valid && !out_sof && !out_eof && !out_bad, "R10", "byte outputs in reset",
          {out_valid, out_sof, out_eof, out_bad}, 0);
      chk(!frm_done && !frm_bad && frm_cause == 0 && !sapi_irq, "R10", "status in reset",
          {frm_done, frm_bad, frm_cause, sapi_irq}, 0);
      chk(good_cnt == 0 && abort_cnt == 0, "R10", "counters in reset",
          {good_cnt, abort_cnt}, 0);
      @(negedge clk) rst_n = 1;
      repeat (2) @(negedge clk);

      build(10, -1, 1, -1); send(0);
      build(20, -1, 1, -1); send(40);
      build(8, -1, 0, -1);  send(0);
      build(12, -1, 1, 3);  send(10);
      for (int k = 0; k < 4; k++) begin build(6, k, 1, -1); send(0); end
      sapi_irq_en = 1; build(6, 2, 1, -1); send(0);
      build(6, -1, 1, -1); send(0);
      sapi_irq_en = 0; build(6, 2, 1, -1); send(0);
      fab = 1; build(9, -1, 1, -1); send(0); fab = 0;
      foreach (fb[n]) if (n < 1) ;
      for (int n = 1; n <= 9; n++) begin
         build(1, -1, 1, -1); flen = n; send(0);
      end
      build(0, -1, 1, -1); send(0);

      quiet = 1;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         in_valid = ($urandom % 4) != 0; in_data = (i % 3 == 0) ? 8'h7D : 8'h7E;
         in_eof = (i % 5 == 4); in_abort = in_eof; in_sof = 0;
      end
      @(negedge clk); in_valid = 0; in_eof = 0; in_abort = 0;
      repeat (3) @(negedge clk);
      quiet = 0;
      chk(quiet_viol == 0, "R11", "output activity outside a frame", quiet_viol, 0);
      chk(rlen == 0, "R11", "stray forwarded bytes", rlen, 0);
      build(7, -1, 1, -1); send(0);

      cfg_addr = 8'h21; cfg_sapi_lo = 8'h07;
      build(5, -1, 1, -1); send(0);
      build(5, 0, 1, -1);  send(0);

      for (int f = 0; f < 90; f++) begin
         int r = int'($urandom % 1000);
         int plen = int'($urandom % 24);
         int hb = (r % 6 == 0) ? int'($urandom % 4) : -1;
         int ea = (r % 7 == 0 && plen >= 2) ? int'($urandom % (plen - 1)) : -1;
         fab = (r % 11 == 0);
         sapi_irq_en = $urandom % 2;
         build(plen, hb, (r % 5) != 0, ea);
         send(int'($urandom % 30));
      end
      fab = 0;

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule